// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block sits between the shift-loaded data register of a column driver and its digital-to-analog stage. When a full row of six-bit gray codes is waiting in the data register, a line-transfer pulse moves the whole row into an output holding register at once. The transfer takes place on the falling edge of that pulse. The row then stays fixed while the next row is shifted in.

Each channel is also assigned one of two reference banks, so that the panel can be driven with dot or line inversion. The upper bank spans reference levels 1 to 5 and the lower bank spans levels 6 to 10. Neighbouring channels always get opposite banks. A polarity input decides which of the two arrangements applies. The block samples polarity when the pulse goes high, and the bank pattern changes only when the row is transferred. For each channel code the block also gives a segment index and an offset, which a later stage uses to pick a tap between two adjacent reference levels.

The latch pulse is sampled on the system clock. A pulse that is sampled high for fewer than `MIN_HIGH` cycles is treated as a glitch and does nothing. A one-cycle output-enable strobe marks each row that is transferred.

Top module: `line_latch_steer`

## Requirements
- R1: When `latch_in` is sampled low one cycle after it was sampled high, and the pulse qualifies (see R6), every field of `code_out` takes the value in `line_codes`. The new row is visible in the cycle after that clock edge.
- R2: `bank_hi[i]`=1 selects the upper bank (levels 1–5) and 0 selects the lower bank (levels 6–10). Channel index i starts at 0, so index 0 is output number 1. With the latched polarity high, even indices get 1 and odd indices get 0. With polarity low, even indices get 0 and odd indices get 1.
- R3: The polarity used for a row is the value of `pol_in` in the first cycle that `latch_in` is sampled high. Changes to `pol_in` later in the same pulse do not affect that row.
- R4: `out_en` is high for exactly one cycle, the cycle in which the new row first appears. It is low at all other times.
- R5: For channel i, `seg_out[2i+1:2i]` is bits 5:4 of its code and `ofs_out[4i+3:4i]` is bits 3:0. Code 0x00 gives segment 0 and offset 0, which is the outermost level of the bank. Code 0x3F gives segment 3 and offset 15, which is the innermost level.
- R6: A pulse sampled high for fewer than `MIN_HIGH` (default 5) cycles is ignored. It changes no code and no bank select, gives no `out_en`, and the polarity it sampled is never applied.
- R7: Between transfers, `code_out`, `seg_out`, `ofs_out` and `bank_hi` hold their values, even when `line_codes` or `pol_in` change.
- R8: While `rst` is high, all codes are 0 and `out_en` is 0. `bank_hi` takes the polarity-low pattern: index 0 gets 0 and index 1 gets 1.
- R9: Adjacent channels are always on opposite banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_codes | input | NUM_CH*CODE_W | Data register contents; channel i is in bits [CODE_W*i +: CODE_W] |
| latch_in | input | 1 | Line-transfer pulse, level sampled on `clk` |
| pol_in | input | 1 | Polarity select for the next row |
| code_out | output | NUM_CH*CODE_W | Held gray codes, same packing as `line_codes` |
| bank_hi | output | NUM_CH | Per-channel reference bank, 1 = upper |
| seg_out | output | NUM_CH*SEG_W | Per-channel segment index |
| ofs_out | output | NUM_CH*(CODE_W-SEG_W) | Per-channel offset inside the segment |
| out_en | output | 1 | One-cycle strobe marking a new row |

## Verification
Four properties are checked on every cycle:
- the strobe lasts a single cycle;
- the strobe always follows a high-then-low pattern on `latch_in`;
- the held codes and banks never move without the strobe;
- adjacent banks always differ.

Some behaviour only the bench scenarios can show:
- that a row qualifies exactly at the `MIN_HIGH` boundary and is dropped one cycle below it;
- that the polarity comes from the rising edge and not from a later change;
- that the data copied is the whole row, including the 0x00 and 0x3F corner codes at the two end channels.

A behavioural model runs next to the design and compares every output on every cycle.

// File: rtl/line_latch_pkg.sv
package line_latch_pkg;

  typedef enum logic {
    BANK_LOWER = 1'b0,
    BANK_UPPER = 1'b1
  } bank_e;

  // odd_idx is bit 0 of the zero-based channel index
  function automatic bank_e pick_bank(input logic pol, input logic odd_idx);
    if (pol)
      return odd_idx ? BANK_LOWER : BANK_UPPER;
    else
      return odd_idx ? BANK_UPPER : BANK_LOWER;
  endfunction

endpackage

// File: rtl/lat_pulse_qual.sv
// Samples the line pulse, measures how long it stays high, captures the
// polarity at its rising edge and fires on a qualified falling edge.
module lat_pulse_qual #(
  parameter int MIN_HIGH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  input  logic pol_in,
  output logic fire,
  output logic pol_line
);
  localparam int CNT_W = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_HIGH);

  logic             pulse_q;
  logic [CNT_W-1:0] high_cnt;
  logic             rise;

  assign rise = pulse_in && !pulse_q;
  assign fire = !pulse_in && pulse_q && (high_cnt >= CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= 1'b0;
      high_cnt <= '0;
      pol_line <= 1'b0;
    end else begin
      pulse_q <= pulse_in;
      if (!pulse_in)
        high_cnt <= '0;
      else if (high_cnt != CNT_MAX)
        high_cnt <= high_cnt + 1'b1;
      if (rise)
        pol_line <= pol_in;
    end
  end
endmodule

// File: rtl/lat_chan.sv
// One output channel: held code, bank select and tap split.
module lat_chan
  import line_latch_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int SEG_W  = 2,
  parameter int IDX    = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    pol,
  input  logic [CODE_W-1:0]       code_in,
  output logic [CODE_W-1:0]       code_q,
  output logic                    bank_q,
  output logic [SEG_W-1:0]        seg,
  output logic [CODE_W-SEG_W-1:0] ofs
);
  localparam logic ODD_IDX = (IDX % 2) == 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      bank_q <= pick_bank(1'b0, ODD_IDX);
    end else if (load) begin
      code_q <= code_in;
      bank_q <= pick_bank(pol, ODD_IDX);
    end
  end

  assign seg = code_q[CODE_W-1 -: SEG_W];
  assign ofs = code_q[CODE_W-SEG_W-1:0];
endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer #(
  parameter int NUM_CH   = 384,
  parameter int CODE_W   = 6,
  parameter int SEG_W    = 2,
  parameter int MIN_HIGH = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH*CODE_W-1:0]       line_codes,
  input  logic                           latch_in,
  input  logic                           pol_in,
  output logic [NUM_CH*CODE_W-1:0]       code_out,
  output logic [NUM_CH-1:0]              bank_hi,
  output logic [NUM_CH*SEG_W-1:0]        seg_out,
  output logic [NUM_CH*(CODE_W-SEG_W)-1:0] ofs_out,
  output logic                           out_en
);
  localparam int OFS_W = CODE_W - SEG_W;

  logic fire;
  logic pol_line;

  lat_pulse_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (latch_in),
    .pol_in   (pol_in),
    .fire     (fire),
    .pol_line (pol_line)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lat_chan #(.CODE_W(CODE_W), .SEG_W(SEG_W), .IDX(g)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .load    (fire),
      .pol     (pol_line),
      .code_in (line_codes[g*CODE_W +: CODE_W]),
      .code_q  (code_out[g*CODE_W +: CODE_W]),
      .bank_q  (bank_hi[g]),
      .seg     (seg_out[g*SEG_W +: SEG_W]),
      .ofs     (ofs_out[g*OFS_W +: OFS_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_en <= 1'b0;
    else     out_en <= fire;
  end
endmodule

// File: rtl/line_latch_steer_chk.sv
module line_latch_steer_chk #(
  parameter int NUM_CH = 384,
  parameter int CODE_W = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     latch_in,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        bank_hi,
  input logic                     out_en
);
  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_en |=> !out_en); // R4

  AST_EN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    out_en |-> ($past(latch_in, 2) && !$past(latch_in))); // R1

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> ($stable(code_out) && $stable(bank_hi))); // R7

  AST_BANK_ALT: assert property (@(posedge clk) disable iff (rst)
    (bank_hi[NUM_CH-2:0] ^ bank_hi[NUM_CH-1:1]) == {(NUM_CH-1){1'b1}}); // R9
endmodule

bind line_latch_steer line_latch_steer_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .latch_in (latch_in),
  .code_out (code_out),
  .bank_hi  (bank_hi),
  .out_en   (out_en)
);

// File: tb/line_latch_steer_bench.sv
module line_latch_steer_bench;
  localparam int NUM_CH   = 384;
  localparam int CODE_W   = 6;
  localparam int SEG_W    = 2;
  localparam int OFS_W    = CODE_W - SEG_W;
  localparam int MIN_HIGH = 5;
  localparam int DW       = NUM_CH * CODE_W;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [DW-1:0]           line_codes = '0;
  logic                    latch_in = 1'b0;
  logic                    pol_in = 1'b0;
  logic [DW-1:0]           code_out;
  logic [NUM_CH-1:0]       bank_hi;
  logic [NUM_CH*SEG_W-1:0] seg_out;
  logic [NUM_CH*OFS_W-1:0] ofs_out;
  logic                    out_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  line_latch_steer #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SEG_W(SEG_W),
                     .MIN_HIGH(MIN_HIGH)) u_line_latch_steer (
    .clk(clk), .rst(rst), .line_codes(line_codes), .latch_in(latch_in),
    .pol_in(pol_in), .code_out(code_out), .bank_hi(bank_hi),
    .seg_out(seg_out), .ofs_out(ofs_out), .out_en(out_en));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] bank_pat(input bit p);
    logic [NUM_CH-1:0] b;
    for (int i = 0; i < NUM_CH; i++) b[i] = p ? (i % 2 == 0) : (i % 2 == 1);
    return b;
  endfunction

  function automatic logic [DW-1:0] make_line(input int mul, input int add);
    logic [DW-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i*CODE_W +: CODE_W] = CODE_W'((i * mul + add) % 64);
    return v;
  endfunction

  // behavioural reference model
  bit            m_prev;
  int            m_cnt;
  bit            m_pend;
  logic [DW-1:0] m_code;
  logic [NUM_CH-1:0] m_bank;
  bit            m_en;

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 0; m_cnt = 0; m_pend = 0; m_code = '0;
      m_bank = bank_pat(1'b0); m_en = 0;
    end else begin
      m_en = 0;
      if (latch_in && !m_prev) m_pend = pol_in;
      if (!latch_in && m_prev && m_cnt >= MIN_HIGH) begin
        m_code = line_codes;
        m_bank = bank_pat(m_pend);
        m_en   = 1;
      end
      m_cnt  = latch_in ? m_cnt + 1 : 0;
      m_prev = latch_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NUM_CH*SEG_W-1:0] es;
      logic [NUM_CH*OFS_W-1:0] eo;
      for (int i = 0; i < NUM_CH; i++) begin
        es[i*SEG_W +: SEG_W] = m_code[i*CODE_W + OFS_W +: SEG_W];
        eo[i*OFS_W +: OFS_W] = m_code[i*CODE_W +: OFS_W];
      end
      chk("R1 model code_out", code_out, m_code);
      chk("R2 model bank_hi", DW'(bank_hi), DW'(m_bank));
      chk("R4 model out_en", DW'(out_en), DW'(m_en));
      chk("R5 model seg_out", DW'(seg_out), DW'(es));
      chk("R5 model ofs_out", DW'(ofs_out), DW'(eo));
    end
  end

  // pulse sampled high for hi cycles; pol p0 at rise, p1 from the 2nd cycle
  task automatic pulse(input int hi, input bit p0, input bit p1);
    @(negedge clk); latch_in = 1'b1; pol_in = p0;
    for (int k = 1; k < hi; k++) begin
      @(negedge clk);
      if (k == 1) pol_in = p1;
    end
    @(negedge clk); latch_in = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] lineA, lineB, lineC;
    lineA = make_line(7, 3);
    lineA[0 +: CODE_W] = 6'h00;
    lineA[(NUM_CH-1)*CODE_W +: CODE_W] = 6'h3F;
    lineB = make_line(11, 40);
    lineC = make_line(5, 17);

    repeat (3) @(negedge clk);
    chk("R8 reset code_out", code_out, '0);
    chk("R8 reset out_en", DW'(out_en), '0);
    chk("R8 reset bank_hi", DW'(bank_hi), DW'(bank_pat(1'b0)));
    rst = 1'b0;
    line_codes = lineA;
    repeat (2) @(negedge clk);

    // qualified at the boundary, pol high
    pulse(MIN_HIGH, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4 strobe after fall", DW'(out_en), DW'(1'b1));
    chk("R1 row copied", code_out, lineA);
    chk("R2 pol high idx0 upper", DW'(bank_hi[0]), DW'(1'b1));
    chk("R2 pol high idx1 lower", DW'(bank_hi[1]), DW'(1'b0));
    chk("R5 code 00 seg", DW'(seg_out[1:0]), DW'(2'd0));
    chk("R5 code 00 ofs", DW'(ofs_out[3:0]), DW'(4'd0));
    chk("R5 code 3F seg", DW'(seg_out[(NUM_CH-1)*SEG_W +: SEG_W]), DW'(2'd3));
    chk("R5 code 3F ofs", DW'(ofs_out[(NUM_CH-1)*OFS_W +: OFS_W]), DW'(4'd15));
    @(negedge clk);
    chk("R4 strobe one cycle", DW'(out_en), DW'(1'b0));

    // data and pol change without a pulse
    line_codes = lineB; pol_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 codes held", code_out, lineA);
    chk("R7 banks held", DW'(bank_hi), DW'(bank_pat(1'b1)));

    // one cycle short: ignored
    pulse(MIN_HIGH - 1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 short pulse no strobe", DW'(out_en), DW'(1'b0));
    repeat (2) @(negedge clk);
    chk("R6 short pulse codes kept", code_out, lineA);
    chk("R6 short pulse bank kept", DW'(bank_hi), DW'(bank_pat(1'b1)));

    // pol low at rise, high afterwards
    pulse(MIN_HIGH + 1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R1 row B copied", code_out, lineB);
    chk("R3 pol from rise idx0", DW'(bank_hi[0]), DW'(1'b0));
    chk("R3 pol from rise all", DW'(bank_hi), DW'(bank_pat(1'b0)));
    chk("R9 neighbours differ", DW'(bank_hi[2] ^ bank_hi[3]), DW'(1'b1));

    // long pulse, pol high at rise, low afterwards
    line_codes = lineC;
    pulse(MIN_HIGH + 4, 1'b1, 1'b0);
    @(negedge clk);
    chk("R1 row C copied", code_out, lineC);
    chk("R2 pol high pattern", DW'(bank_hi), DW'(bank_pat(1'b1)));
    chk("R5 ch5 seg", DW'(seg_out[5*SEG_W +: SEG_W]), DW'(lineC[5*CODE_W + OFS_W +: SEG_W]));
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule